// File: doc/BRIEF.md
# Triggered Event Serializer with Bunch-Crossing Time Stamp

This block turns one wide detector event into a short burst of narrow words. A trigger arms a small delay counter that is preset from a 3-bit offset, so the moment of capture can be moved to match the latency of the front end. While the block is idle or waiting, a 128-bit capture register follows the event input on every clock. When the delay expires, the register freezes. In the same cycle, the current value of a free-running 6-bit bunch-crossing counter is copied as the event's time stamp.

The frozen event then leaves on a 14-bit output stream in a fixed order:
- one header word that carries the time stamp;
- eleven payload words of 12 bits each, least-significant slice first;
- then an internal end-of-event reset, which clears the bunch-crossing counter and re-arms capture.

The two clocks of the system are modelled as related. The bunch-crossing clock is a one-cycle strobe, `bx_tick`, in the read-clock domain.

The output is a valid/ready stream with these back-pressure rules:
- `out_valid` stays high through all twelve words.
- A word is accepted on a rising clock edge where both `out_valid` and `out_ready` are high.
- While `out_ready` is low, the word is held unchanged.
- The trigger, offset and bunch-crossing inputs are plain control pins with no handshake.

Top module: `evser_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid` and `sync_rst` are 0.
- R2: A trigger seen while idle loads the delay counter with `offset`. The counter then increments once per clock. Output starts on the clock edge that follows the cycle in which the counter equals 2. So the header is first visible ((2 - offset) mod 8) + 2 clock edges after the trigger edge: 4 for offset 0, 3 for offset 1, 2 for offset 2, 9 for offset 3.
- R3: The first word of an event has `out_word[13]` (data_valid) = 0, `out_word[12]` (data_ctrl) = 1, and `out_word[11:0]` = the time stamp, zero-extended.
- R4: Words 2 to 12 each have data_valid = 1 and data_ctrl = 0. Payload word k (k = 0..10) carries event bits [12k+11:12k]. Bits above 127 are sent as 0, so the top 4 bits of the last slice are zero.
- R5: The event sent is the value of `ev_data` in the last cycle before output starts. Changes to `ev_data` after that point do not alter the event.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_word` stays the same on the next cycle. The sequence advances only on accepted words.
- R7: In the cycle after the twelfth word is accepted, `sync_rst` is 1 for exactly one cycle with `out_valid` = 0. After that, the block is idle and accepts a new trigger.
- R8: A trigger that arrives while the block is waiting, sending or in the end-of-event cycle is ignored. No extra event follows.
- R9: The bunch-crossing counter adds 1 (modulo 64) on each clock edge where `bx_tick` is 1. It is cleared on the edge that ends a `sync_rst` cycle, and by `rst_n`. The time stamp is the counter value just before the edge on which output starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock; all state changes on its rising edge |
| rst_n | input | 1 | Manual reset, asynchronous, active low |
| bx_tick | input | 1 | One-cycle bunch-crossing strobe that advances the time-stamp counter |
| trig | input | 1 | Trigger request, sampled while idle |
| offset | input | 3 | Delay preset loaded on trigger |
| ev_data | input | 128 | Parallel event input |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_word | output | 14 | {data_valid, data_ctrl, payload[11:0]} |
| sync_rst | output | 1 | One-cycle end-of-event pulse |

## Verification
The assertions assume three things about the inputs:
- `out_ready` and `bx_tick` change only away from the active edge.
- `out_ready` may drop at any time, including in the middle of an event.
- `offset` and `ev_data` are steady from the trigger until capture.

The stimulus drives every input on the falling edge. It holds `offset` and `ev_data` constant through the delay window, and changes `ev_data` only after the header has gone out. It sweeps all eight offsets with three event patterns, each with an always-ready consumer and with one that stalls one cycle in three. Stray triggers are injected mid-burst, and one event runs with the bunch-crossing strobe silenced so that the clear after `sync_rst` can be seen on its own.

// File: rtl/evser_pkg.sv
package evser_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_PUSH = 2'd2,
    ST_SYNC = 2'd3
  } evser_state_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/evser_delay.sv
module evser_delay
  import evser_pkg::*;
#(
  parameter int OFF_W     = 3,
  parameter int START_VAL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [OFF_W-1:0] offset,
  input  logic             push_done,
  output logic             push_o,
  output logic             sync_o
);

  localparam logic [OFF_W-1:0] START = OFF_W'(START_VAL);

  evser_state_e     state_q;
  logic [OFF_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (trig) begin
            state_q <= ST_WAIT;
            cnt_q   <= offset;
          end
        end
        ST_WAIT: begin
          if (cnt_q == START) state_q <= ST_PUSH;
          else                cnt_q   <= cnt_q + 1'b1;
        end
        ST_PUSH: begin
          if (push_done) state_q <= ST_SYNC;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign push_o = (state_q == ST_PUSH);
  assign sync_o = (state_q == ST_SYNC);

  // R2
  wait_to_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && cnt_q == START) |=> (state_q == ST_PUSH));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH) |=> (state_q == ST_PUSH || state_q == ST_SYNC));

  // R7
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SYNC) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/evser_capture.sv
module evser_capture #(
  parameter int DATA_W = 128,
  parameter int TS_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [DATA_W-1:0] din,
  input  logic [TS_W-1:0]   ts_in,
  output logic [DATA_W-1:0] data_q,
  output logic [TS_W-1:0]   ts_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ts_q   <= '0;
    end else if (!hold) begin
      data_q <= din;
      ts_q   <= ts_in;
    end
  end

  // R5
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!hold || ($stable(data_q) && $stable(ts_q))));

endmodule

// File: rtl/evser_bxcount.sv
module evser_bxcount #(
  parameter int TS_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            clr,
  output logic [TS_W-1:0] cnt_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  // R9
  bx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> (cnt_q == TS_W'($past(cnt_q) + 1'b1)));

  // R9
  bx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/evser_slicer.sv
module evser_slicer
  import evser_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int SLICE_W = 12,
  parameter int TS_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               ready,
  input  logic [DATA_W-1:0]  data,
  input  logic [TS_W-1:0]    ts,
  output logic               valid_o,
  output logic [SLICE_W+1:0] word_o,
  output logic               done_o
);

  localparam int NSLICE = ceil_div(DATA_W, SLICE_W);
  localparam int PAD_W  = NSLICE * SLICE_W;
  localparam int SEQ_W  = $clog2(NSLICE + 3);
  localparam int IDX_W  = $clog2(NSLICE);
  localparam logic [SEQ_W-1:0] HDR  = SEQ_W'(1);
  localparam logic [SEQ_W-1:0] LAST = SEQ_W'(NSLICE + 1);

  logic [PAD_W-1:0]   padded;
  logic [SLICE_W-1:0] slices [NSLICE];
  logic [SEQ_W-1:0]   seq_q;
  logic [SEQ_W-1:0]   idx;
  logic [SLICE_W-1:0] payload;
  logic               fire;

  assign padded = PAD_W'(data);

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    assign slices[g] = padded[g*SLICE_W +: SLICE_W];
  end

  assign fire    = active && ready;
  assign done_o  = fire && (seq_q == LAST);
  assign valid_o = active;
  assign idx     = seq_q - SEQ_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seq_q <= HDR;
    else if (!active) seq_q <= HDR;
    else if (fire)    seq_q <= seq_q + 1'b1;
  end

  always_comb begin
    payload = '0;
    if (seq_q >= SEQ_W'(2) && seq_q <= LAST) payload = slices[idx[IDX_W-1:0]];
  end

  always_comb begin
    if (seq_q == HDR) word_o = {1'b0, 1'b1, SLICE_W'(ts)};
    else              word_o = {1'b1, 1'b0, payload};
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready) |=> (valid_o && $stable(word_o)));

  // R4
  seq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (seq_q >= HDR && seq_q <= LAST));

  // R3
  header_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> (word_o[SLICE_W] && !word_o[SLICE_W+1]));

endmodule

// File: rtl/evser_top.sv
module evser_top #(
  parameter int DATA_W    = 128,
  parameter int SLICE_W   = 12,
  parameter int TS_W      = 6,
  parameter int OFF_W     = 3,
  parameter int START_VAL = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bx_tick,
  input  logic               trig,
  input  logic [OFF_W-1:0]   offset,
  input  logic [DATA_W-1:0]  ev_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SLICE_W+1:0] out_word,
  output logic               sync_rst
);

  logic              push;
  logic              done;
  logic [TS_W-1:0]   bx_cnt;
  logic [TS_W-1:0]   ts_q;
  logic [DATA_W-1:0] data_q;

  evser_delay #(.OFF_W(OFF_W), .START_VAL(START_VAL)) u_delay (
    .clk(clk), .rst_n(rst_n), .trig(trig), .offset(offset),
    .push_done(done), .push_o(push), .sync_o(sync_rst)
  );

  evser_bxcount #(.TS_W(TS_W)) u_bx (
    .clk(clk), .rst_n(rst_n), .tick(bx_tick), .clr(sync_rst), .cnt_q(bx_cnt)
  );

  evser_capture #(.DATA_W(DATA_W), .TS_W(TS_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .hold(push), .din(ev_data), .ts_in(bx_cnt),
    .data_q(data_q), .ts_q(ts_q)
  );

  evser_slicer #(.DATA_W(DATA_W), .SLICE_W(SLICE_W), .TS_W(TS_W)) u_slice (
    .clk(clk), .rst_n(rst_n), .active(push), .ready(out_ready),
    .data(data_q), .ts(ts_q), .valid_o(out_valid), .word_o(out_word),
    .done_o(done)
  );

  // R4
  ctrl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word[SLICE_W+1] ^ out_word[SLICE_W]));

  // R7
  sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rst |-> (!out_valid ##1 !sync_rst));

endmodule

// File: tb/evser_top_test.sv
module evser_top_test;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bx_tick = 1'b0;
  logic         trig = 1'b0;
  logic [2:0]   offset = '0;
  logic [127:0] ev_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [13:0]  out_word;
  logic         sync_rst;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit bx_en = 1'b1;
  int bx_phase = 0;
  logic [5:0] bx_model = '0;
  logic [5:0] bx_hist = '0;

  evser_top uut (
    .clk(clk), .rst_n(rst_n), .bx_tick(bx_tick), .trig(trig), .offset(offset),
    .ev_data(ev_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .sync_rst(sync_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    bx_phase <= bx_phase + 1;
    bx_tick  <= bx_en && (bx_phase % 3 != 2);
  end

  always @(posedge clk) begin
    bx_hist <= bx_model;
    if (!rst_n)        bx_model <= '0;
    else if (sync_rst) bx_model <= '0;
    else if (bx_tick)  bx_model <= bx_model + 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] exp_word(input int k, input logic [127:0] d,
                                           input logic [5:0] ts);
    logic [131:0] pad;
    pad = {4'b0, d};
    if (k == 0) return {2'b01, 6'b0, ts};
    return {2'b10, pad[(k-1)*12 +: 12]};
  endfunction

  function automatic logic [127:0] pattern(input int p, input int off);
    logic [127:0] v;
    for (int i = 0; i < 4; i++)
      v[i*32 +: 32] = 32'h9E3779B9 * (p * 8 + off + i + 1) ^ (32'h1 << (i * 7 + p));
    return v;
  endfunction

  task automatic run_event(input logic [2:0] off, input logic [127:0] d,
                           input bit stall, input bit poke, input bit freeze,
                           input bit expect_zero_ts);
    int n;
    int idx;
    int k;
    int guard;
    bit rdy;
    bit was_stalled;
    logic [5:0] ts;
    @(negedge clk);
    offset = off; ev_data = d; trig = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      trig = 1'b0;
      n++;
    end while (!out_valid && n < 20);
    // R2: latency of the header word
    chk(n == (((2 - off) & 7) + 2), "R2 delay", 64'(n), 64'(((2 - off) & 7) + 2));
    ts = bx_hist;
    if (expect_zero_ts) chk(ts == 6'd0, "R9 clear after sync", 64'(ts), 64'd0);
    idx = 0; k = 0; guard = 0; was_stalled = 1'b0;
    while (idx < 12 && guard < 100) begin
      guard++;
      if (idx == 0)
        chk(out_valid && out_word == exp_word(0, d, ts), "R3 header",
            64'(out_word), 64'(exp_word(0, d, ts)));
      else if (was_stalled)
        chk(out_valid && out_word == exp_word(idx, d, ts), "R6 held word",
            64'(out_word), 64'(exp_word(idx, d, ts)));
      else
        chk(out_valid && out_word == exp_word(idx, d, ts),
            freeze ? "R5 frozen payload" : "R4 payload",
            64'(out_word), 64'(exp_word(idx, d, ts)));
      rdy = stall ? (k % 3 != 0) : 1'b1;
      out_ready = rdy;
      was_stalled = !rdy;
      if (rdy) idx++;
      if (freeze && idx == 1) ev_data = ~d;
      trig = (poke && idx == 5);
      k++;
      @(negedge clk);
    end
    trig = 1'b0;
    out_ready = 1'b0;
    // R7: end-of-event pulse
    chk(sync_rst && !out_valid, "R7 sync pulse", {sync_rst, out_valid}, 64'b10);
    @(negedge clk);
    chk(!sync_rst && !out_valid, "R7 back to idle", {sync_rst, out_valid}, 64'b00);
    if (poke) begin
      bit seen = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (out_valid) seen = 1'b1;
      end
      // R8: stray trigger ignored
      chk(!seen, "R8 busy trigger ignored", 64'(seen), 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk(!out_valid && !sync_rst, "R1 in reset", {out_valid, sync_rst}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !sync_rst, "R1 after reset", {out_valid, sync_rst}, 64'd0);
    for (int off = 0; off < 8; off++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s < 2; s++)
          run_event(3'(off), pattern(p, off), s[0], (s == 1 && p == 0), (p == 1), 1'b0);
    // R9: no strobes since the last sync, so the stamp must be zero
    bx_en = 1'b0;
    repeat (2) @(negedge clk);
    run_event(3'd2, {4{32'hA5C3_0F1E}}, 1'b0, 1'b0, 1'b0, 1'b1);
    bx_en = 1'b1;
    run_event(3'd1, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule